// File: doc/BRIEF.md
# Data-Strobe Serial Transmit Encoder

This block turns a stream of parallel bytes into a two-wire serial code in which one line carries the bit value and a companion strobe line changes only when the value line does not. Every bit period therefore shows exactly one transition across the pair. A receiver can recover timing from that transition without a separate bit clock. One bit leaves per cycle of the single local clock, and the most significant bit of each byte goes first.

Bytes arrive from one of two producers: the repeat path of a port that is receiving, or the local link interface. A select input picks the producer. Each producer has its own valid/ready handshake and an end-of-packet flag. The single encoded stream is driven in the same cycle onto every port whose bit is set in an active-port mask. Ports that are not active stay at zero with their enable low. Between packets all enables are low and the encoder state returns to zero, so every packet starts from the same line levels.

Top module: `ds_tx_encoder`

## Requirements
- R1: During and after reset, all tx_en, tx_data and tx_strb bits are 0, and the ready of the selected source is 1.
- R2: A byte accepted at clock edge k appears on tx_data of the active ports MSB first, one bit per cycle, starting in the cycle after edge k+1.
- R3: On each new bit, tx_data takes the bit value. tx_strb inverts when the new bit equals the previous tx_data value and holds otherwise, so exactly one of the two lines changes per bit.
- R4: The code state is tx_data=0 and tx_strb=0 before the first bit of every packet. A first bit of 1 therefore gives data=1/strobe=0, and a first bit of 0 gives data=0/strobe=1.
- R5: All ports that are active carry identical tx_data, tx_strb and tx_en in every cycle.
- R6: A port whose port_active bit is 0 has tx_en, tx_data and tx_strb at 0.
- R7: src_sel=0 selects the repeat source and src_sel=1 selects the link source. Only the selected source sees ready; the valid of the other source is ignored and never starts output.
- R8: ready is low while a byte is shifting out. For a byte whose last flag is 0, ready is high during the cycle in which that byte's final bit is being shifted out, so a waiting next byte follows with no gap.
- R9: After the final bit of a byte flagged last has been shown for one cycle, the enables of all ports drop and tx_data and tx_strb return to 0.
- R10: If no byte is offered after a byte whose last flag is 0, the lines hold their levels and the enables stay high until the next byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local transmit clock, one bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 1 | 0 = repeat source, 1 = link source |
| rpt_data | input | BYTE_W | Repeat source byte |
| rpt_valid | input | 1 | Repeat source byte valid |
| rpt_last | input | 1 | Repeat source byte ends the packet |
| rpt_ready | output | 1 | Repeat source byte accepted this edge when valid |
| lnk_data | input | BYTE_W | Link source byte |
| lnk_valid | input | 1 | Link source byte valid |
| lnk_last | input | 1 | Link source byte ends the packet |
| lnk_ready | output | 1 | Link source byte accepted this edge when valid |
| port_active | input | NUM_PORTS | Mask of ports that receive the stream |
| tx_data | output | NUM_PORTS | Per-port data line |
| tx_strb | output | NUM_PORTS | Per-port strobe line |
| tx_en | output | NUM_PORTS | Per-port driver enable |

## Verification
The assertions take for granted that src_sel does not change while a packet is in flight. They also assume that an active-mask bit does not change during a packet, because the step and start checks compare each port with its own state one cycle earlier. The stimulus changes src_sel and port_active only while the encoder is idle, between packets, and keeps each source's valid, data and last steady until the byte is taken. The one exception is a deliberate valid pulse on the unselected source, which exercises the rule that such input is ignored.

// File: rtl/ds_tx_pkg.sv
// Shared definitions for the data-strobe transmit encoder.
package ds_tx_pkg;
    // Source selection code carried on src_sel.
    typedef enum logic {
        SRC_REPEAT = 1'b0,
        SRC_LINK   = 1'b1
    } ds_src_e;

    // Next strobe level: invert when the data line does not change.
    function automatic logic next_strobe(input logic new_bit, input logic cur_data,
                                         input logic cur_strb);
        return (new_bit == cur_data) ? ~cur_strb : cur_strb;
    endfunction
endpackage

// File: rtl/ds_src_mux.sv
// Picks one of two byte producers and routes the shared ready back to it.
// Assumes: sel is steady for the length of a packet.
module ds_src_mux
    import ds_tx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              sel,
    input  logic [BYTE_W-1:0] rpt_data,
    input  logic              rpt_valid,
    input  logic              rpt_last,
    output logic              rpt_ready,
    input  logic [BYTE_W-1:0] lnk_data,
    input  logic              lnk_valid,
    input  logic              lnk_last,
    output logic              lnk_ready,
    input  logic              ready_in,
    output logic              valid_out,
    output logic [BYTE_W-1:0] data_out,
    output logic              last_out
);
    logic use_link;
    assign use_link = (ds_src_e'(sel) == SRC_LINK);

    // Forward the chosen producer and gate ready to it alone.
    always_comb begin
        valid_out = use_link ? lnk_valid : rpt_valid;
        data_out  = use_link ? lnk_data  : rpt_data;
        last_out  = use_link ? lnk_last  : rpt_last;
        rpt_ready = ready_in & ~use_link;
        lnk_ready = ready_in &  use_link;
    end
endmodule

// File: rtl/ds_serializer.sv
// Parallel-to-serial shifter, MSB first, one bit per clock.
// Takes a new byte when empty, or in the final-bit cycle of a byte that does
// not end the packet. Marks the final bit of a packet with bit_end.
module ds_serializer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              bit_valid,
    output logic              bit_val,
    output logic              bit_end
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bits_left;
    logic              cur_last;
    logic              busy;

    // Handshake and bit outputs derived from the shifter state.
    always_comb begin
        busy      = (bits_left != '0);
        in_ready  = ~busy | ((bits_left == ONE) & ~cur_last);
        bit_valid = busy;
        bit_val   = shreg[BYTE_W-1];
        bit_end   = busy & (bits_left == ONE) & cur_last;
    end

    // Load a byte on handshake, otherwise shift while bits remain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            cur_last  <= 1'b0;
        end else if (in_valid && in_ready) begin
            shreg     <= in_data;
            bits_left <= FULL;
            cur_last  <= in_last;
        end else if (busy) begin
            shreg     <= {shreg[BYTE_W-2:0], 1'b0};
            bits_left <= bits_left - ONE;
        end
    end
endmodule

// File: rtl/ds_line_coder.sv
// Data/strobe state machine: one transition on the pair per bit.
// Returns to data=0, strobe=0, off one cycle after the packet's final bit.
module ds_line_coder
    import ds_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_val,
    input  logic bit_end,
    output logic line_d,
    output logic line_s,
    output logic line_on
);
    logic fin;

    // Advance the code on each bit; clear the state after the packet ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_d  <= 1'b0;
            line_s  <= 1'b0;
            line_on <= 1'b0;
            fin     <= 1'b0;
        end else if (bit_valid) begin
            line_d  <= bit_val;
            line_s  <= next_strobe(bit_val, line_d, line_s);
            line_on <= 1'b1;
            fin     <= bit_end;
        end else if (fin) begin
            line_d  <= 1'b0;
            line_s  <= 1'b0;
            line_on <= 1'b0;
            fin     <= 1'b0;
        end
    end
endmodule

// File: rtl/ds_port_fanout.sv
// Copies one coded pair onto every active port; inactive ports stay at zero.
// Assumes: the mask is applied without delay, in the same cycle.
module ds_port_fanout #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 line_d,
    input  logic                 line_s,
    input  logic                 line_on,
    input  logic [NUM_PORTS-1:0] port_active,
    output logic [NUM_PORTS-1:0] tx_data,
    output logic [NUM_PORTS-1:0] tx_strb,
    output logic [NUM_PORTS-1:0] tx_en
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic drive;
        // Gate the shared pair with this port's active bit.
        always_comb begin
            drive      = line_on & port_active[p];
            tx_en[p]   = drive;
            tx_data[p] = drive & line_d;
            tx_strb[p] = drive & line_s;
        end
    end
endmodule

// File: rtl/ds_tx_encoder.sv
// Top of the data-strobe transmit encoder: source select, shifter, line
// coder and port fan-out. Assumes src_sel and port_active are steady while
// a packet is sent.
module ds_tx_encoder #(
    parameter int BYTE_W    = 8,
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 src_sel,
    input  logic [BYTE_W-1:0]    rpt_data,
    input  logic                 rpt_valid,
    input  logic                 rpt_last,
    output logic                 rpt_ready,
    input  logic [BYTE_W-1:0]    lnk_data,
    input  logic                 lnk_valid,
    input  logic                 lnk_last,
    output logic                 lnk_ready,
    input  logic [NUM_PORTS-1:0] port_active,
    output logic [NUM_PORTS-1:0] tx_data,
    output logic [NUM_PORTS-1:0] tx_strb,
    output logic [NUM_PORTS-1:0] tx_en
);
    logic              sel_valid, sel_last, sh_ready;
    logic [BYTE_W-1:0] sel_data;
    logic              bit_valid, bit_val, bit_end;
    logic              line_d, line_s, line_on;

    ds_src_mux #(.BYTE_W(BYTE_W)) u_mux (
        .sel(src_sel),
        .rpt_data(rpt_data), .rpt_valid(rpt_valid), .rpt_last(rpt_last), .rpt_ready(rpt_ready),
        .lnk_data(lnk_data), .lnk_valid(lnk_valid), .lnk_last(lnk_last), .lnk_ready(lnk_ready),
        .ready_in(sh_ready),
        .valid_out(sel_valid), .data_out(sel_data), .last_out(sel_last)
    );

    ds_serializer #(.BYTE_W(BYTE_W)) u_ser (
        .clk(clk), .rst_n(rst_n),
        .in_valid(sel_valid), .in_data(sel_data), .in_last(sel_last), .in_ready(sh_ready),
        .bit_valid(bit_valid), .bit_val(bit_val), .bit_end(bit_end)
    );

    ds_line_coder u_code (
        .clk(clk), .rst_n(rst_n),
        .bit_valid(bit_valid), .bit_val(bit_val), .bit_end(bit_end),
        .line_d(line_d), .line_s(line_s), .line_on(line_on)
    );

    ds_port_fanout #(.NUM_PORTS(NUM_PORTS)) u_fan (
        .line_d(line_d), .line_s(line_s), .line_on(line_on),
        .port_active(port_active),
        .tx_data(tx_data), .tx_strb(tx_strb), .tx_en(tx_en)
    );
endmodule

// File: rtl/ds_tx_checker.sv
// Port-level properties of the data-strobe transmit encoder, bound to the top.
module ds_tx_checker #(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rpt_ready,
    input logic                 lnk_ready,
    input logic [NUM_PORTS-1:0] port_active,
    input logic [NUM_PORTS-1:0] tx_data,
    input logic [NUM_PORTS-1:0] tx_strb,
    input logic [NUM_PORTS-1:0] tx_en
);
    AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !(rpt_ready && lnk_ready)); // R7

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        AST_PAIR_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_en[p] && $past(tx_en[p])) |->
            ($countones({tx_data[p] ^ $past(tx_data[p]), tx_strb[p] ^ $past(tx_strb[p])}) <= 1)); // R3
        AST_EN_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            tx_en[p] |-> port_active[p]); // R6
        AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_en[p] |-> (!tx_data[p] && !tx_strb[p])); // R9
        AST_SAME_AS_PORT0: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_en[p] && tx_en[0]) |-> (tx_data[p] == tx_data[0] && tx_strb[p] == tx_strb[0])); // R5
        AST_START_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(tx_en[p]) && $past(port_active[p])) |->
            ($countones({tx_data[p], tx_strb[p]}) == 1)); // R4
    end
endmodule

bind ds_tx_encoder ds_tx_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rpt_ready(rpt_ready), .lnk_ready(lnk_ready),
    .port_active(port_active), .tx_data(tx_data), .tx_strb(tx_strb), .tx_en(tx_en)
);

// File: tb/sim_ds_tx_encoder.sv
module sim_ds_tx_encoder;
    localparam int BW = 8;
    localparam int NP = 4;
    // Vector: {src_sel, port mask[3:0], byte[7:0]}
    localparam int NV = 8;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 4'b1111, 8'hA5}, {1'b1, 4'b0101, 8'h00}, {1'b0, 4'b0010, 8'hFF},
        {1'b1, 4'b1000, 8'hAA}, {1'b0, 4'b1011, 8'h55}, {1'b1, 4'b0000, 8'h3C},
        {1'b1, 4'b1111, 8'h81}, {1'b0, 4'b0110, 8'h7E}
    };

    logic clk = 0, rst_n = 0, src_sel = 0;
    logic [BW-1:0] rpt_data = 0, lnk_data = 0;
    logic rpt_valid = 0, rpt_last = 0, lnk_valid = 0, lnk_last = 0;
    logic rpt_ready, lnk_ready;
    logic [NP-1:0] port_active = 0, tx_data, tx_strb, tx_en;
    int checks = 0, errors = 0;
    bit done = 0;
    logic md, ms; // bench model of the code state

    always #2 clk = ~clk;

    ds_tx_encoder #(.BYTE_W(BW), .NUM_PORTS(NP)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_lines(input string req, input logic [NP-1:0] m,
                               input logic ed, input logic es, input logic eon);
        logic [3*NP-1:0] e;
        e = {eon ? m : '0, (eon && ed) ? m : '0, (eon && es) ? m : '0};
        check(req, 32'({tx_en, tx_data, tx_strb}), 32'(e));
    endtask

    task automatic drive(input logic v, input logic [BW-1:0] d, input logic l);
        if (src_sel) begin lnk_valid = v; lnk_data = d; lnk_last = l; end
        else begin rpt_valid = v; rpt_data = d; rpt_last = l; end
    endtask

    // Offer a byte for one edge (ready is expected high).
    task automatic send_byte(input logic [BW-1:0] d, input logic l);
        @(negedge clk); drive(1, d, l);
        @(negedge clk); drive(0, 0, 0);
    endtask

    // Sample eight bits, MSB first, against the model.
    task automatic check_bits(input string req, input logic [BW-1:0] d, input logic [NP-1:0] m);
        for (int i = BW - 1; i >= 0; i--) begin
            @(negedge clk);
            ms = (d[i] == md) ? ~ms : ms;
            md = d[i];
            check_lines(req, m, md, ms, 1'b1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        port_active = 4'b1111;
        repeat (3) @(negedge clk);
        check_lines("R1 in reset", 4'b1111, 0, 0, 0);
        rst_n = 1;
        @(negedge clk);
        check_lines("R1 after reset", 4'b1111, 0, 0, 0);
        check("R1 ready", 32'({rpt_ready, lnk_ready}), 32'b10);

        // Table: single-byte packets, R2 R3 R4 R5 R6 R9
        foreach (VEC[v]) begin
            src_sel = VEC[v][12];
            port_active = VEC[v][11:8];
            md = 0; ms = 0;
            send_byte(VEC[v][7:0], 1'b1);
            check_bits("R2 R3 R4 R5 R6 table", VEC[v][7:0], VEC[v][11:8]);
            @(negedge clk);
            check_lines("R9 packet end", VEC[v][11:8], 0, 0, 0);
        end

        // R8: back-to-back bytes with no gap
        src_sel = 1; port_active = 4'b1101; md = 0; ms = 0;
        @(negedge clk); drive(1, 8'hC3, 0);
        @(negedge clk); drive(1, 8'h0F, 1);
        for (int k = 0; k < 16; k++) begin
            logic b;
            @(negedge clk);
            b = (k < 8) ? 8'hC3 >> (7 - k) : 8'h0F >> (15 - k);
            ms = (b == md) ? ~ms : ms; md = b;
            check_lines("R8 R3 back to back", 4'b1101, md, ms, 1);
            if (k == 0) check("R8 ready low while shifting", 32'(lnk_ready), 0);
            if (k == 6) check("R8 ready in final-bit cycle", 32'(lnk_ready), 1);
            if (k == 7) drive(0, 0, 0);
        end
        @(negedge clk);
        check_lines("R9 after two-byte packet", 4'b1101, 0, 0, 0);

        // R10: gap inside a packet holds the lines
        src_sel = 0; port_active = 4'b0011; md = 0; ms = 0;
        send_byte(8'h96, 0);
        check_bits("R2 first byte", 8'h96, 4'b0011);
        repeat (3) begin
            @(negedge clk);
            check_lines("R10 hold during gap", 4'b0011, md, ms, 1);
        end
        send_byte(8'h21, 1);
        check_lines("R10 hold before next byte", 4'b0011, md, ms, 1);
        check_bits("R3 continue after gap", 8'h21, 4'b0011);
        @(negedge clk);
        check_lines("R9 end after gap", 4'b0011, 0, 0, 0);

        // R7: unselected source is ignored
        src_sel = 1; port_active = 4'b1111;
        @(negedge clk); rpt_valid = 1; rpt_data = 8'hFF; rpt_last = 1;
        @(negedge clk);
        check("R7 ready only to link", 32'({rpt_ready, lnk_ready}), 32'b01);
        repeat (4) @(negedge clk);
        check_lines("R7 unselected valid ignored", 4'b1111, 0, 0, 0);
        rpt_valid = 0; rpt_last = 0;
        src_sel = 0;
        @(negedge clk);
        check("R7 ready only to repeat", 32'({rpt_ready, lnk_ready}), 32'b10);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule